// File: doc/BRIEF.md
# Integer ALU Execute Stage

This block is the execute stage for the register-to-register and register-to-immediate arithmetic and logic instructions of a 32-bit three-operand RISC instruction set. Each cycle it can accept one 32-bit instruction word and the two operand values that the register file read for the instruction's source fields. One clock later it returns the 32-bit result, the index of the register to write and a write strobe.

The instructions it handles are addition and subtraction, the four bitwise operations, three shifts by a constant amount and three shifts by a register amount, the immediate forms of add, and, or and xor, and the load-upper form. Immediates are always zero-extended, and that includes the signed-add opcode. Signed and unsigned additions give the same result and never trap.

Any opcode or function code outside that set produces no write. It raises an illegal-instruction flag for the cycle instead. Multiply, divide, memory access, branches and the register file itself sit outside this block.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst_n` is low, and on the first rising edge after it is released, `out_valid`, `wr_en`, `illegal`, `result` and `dest_idx` are all zero.
- R2: `out_valid` equals `in_valid` delayed by one rising clock edge. In any cycle where `out_valid` is 0, `wr_en`, `illegal`, `result` and `dest_idx` are all 0.
- R3: With opcode `instr[31:26]` = 0, function `instr[5:0]` 0x20 or 0x21 gives A+B and 0x22 or 0x23 gives A-B, both modulo 2^32. A is the operand selected by `instr[25:21]`, B is the operand selected by `instr[20:16]`, and the destination is `instr[15:11]`.
- R4: With opcode 0, function 0x24 gives A AND B, 0x25 gives A OR B, 0x26 gives A XOR B and 0x27 gives NOT(A OR B).
- R5: With opcode 0, functions 0x00, 0x02 and 0x03 shift B by `instr[10:6]`. 0x00 shifts left, 0x02 shifts right logically and 0x03 shifts right arithmetically. The field `instr[25:21]` has no effect on these three.
- R6: With opcode 0, functions 0x04, 0x06 and 0x07 shift B left, right logically and right arithmetically, by the low 5 bits of A.
- R7: Opcodes 0x08 and 0x09 give A + imm, 0x0C gives A AND imm, 0x0D gives A OR imm and 0x0E gives A XOR imm. Here imm is `instr[15:0]` zero-extended to 32 bits. The destination is `instr[20:16]`.
- R8: Opcode 0x0F with `instr[25:21]` = 0 gives `{instr[15:0], 16'h0000}` with destination `instr[20:16]`.
- R9: A source index of 0 supplies the value 0, whatever value is on the matching operand input.
- R10: Any other opcode or function code, or opcode 0x0F with a nonzero `instr[25:21]`, gives `illegal` = 1, `wr_en` = 0, `result` = 0 and `dest_idx` = 0.
- R11: A legal instruction whose destination index is 0 gives `wr_en` = 0 and `illegal` = 0, with the result still presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value read for the register in instr[25:21] |
| rt_val | input | 32 | Value read for the register in instr[20:16] |
| out_valid | output | 1 | The outputs carry a result this cycle |
| result | output | 32 | Computed value |
| dest_idx | output | 5 | Register index to write |
| wr_en | output | 1 | Write strobe for dest_idx |
| illegal | output | 1 | Instruction not recognised |

## Verification
The only state in this block is the output register, so a bad decode or a bad operand path shows up at the ports on the very next cycle as a wrong result, index or strobe. A behavioural model in the bench predicts every output field for every accepted instruction and compares them all on every clock.

The model catches a missing zero-extension, a mis-swapped shift operand or a source field that is ignored when it should be honoured within one instruction of the first one that exercises the path. It also catches a stale value left over from an idle cycle.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_ADDIU = 6'h09;
    localparam logic [5:0] OPC_ANDI  = 6'h0C;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_XORI  = 6'h0E;
    localparam logic [5:0] OPC_LUI   = 6'h0F;

    localparam logic [5:0] FN_SLL  = 6'h00;
    localparam logic [5:0] FN_SRL  = 6'h02;
    localparam logic [5:0] FN_SRA  = 6'h03;
    localparam logic [5:0] FN_SLLV = 6'h04;
    localparam logic [5:0] FN_SRLV = 6'h06;
    localparam logic [5:0] FN_SRAV = 6'h07;
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_ADDU = 6'h21;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_SUBU = 6'h23;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_XOR  = 6'h26;
    localparam logic [5:0] FN_NOR  = 6'h27;

    localparam int IMM_W = 16;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
        ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
    } alu_op_e;

    typedef struct packed {
        alu_op_e    op;
        logic       use_imm;
        logic       var_amt;
        logic       is_shift;
        logic [4:0] dest;
        logic       legal;
    } dec_s;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [31:0] instr,
    output dec_s        dec
);
    logic [5:0] opc;
    logic [5:0] fn;

    assign opc = instr[31:26];
    assign fn  = instr[5:0];

    always_comb begin
        dec       = '0;
        dec.op    = ALU_ADD;
        dec.legal = 1'b1;
        if (opc == OPC_REG) begin
            dec.dest = instr[15:11];
            case (fn)
                FN_ADD, FN_ADDU: dec.op = ALU_ADD;
                FN_SUB, FN_SUBU: dec.op = ALU_SUB;
                FN_AND:          dec.op = ALU_AND;
                FN_OR:           dec.op = ALU_OR;
                FN_XOR:          dec.op = ALU_XOR;
                FN_NOR:          dec.op = ALU_NOR;
                FN_SLL:  begin dec.op = ALU_SLL; dec.is_shift = 1'b1; end
                FN_SRL:  begin dec.op = ALU_SRL; dec.is_shift = 1'b1; end
                FN_SRA:  begin dec.op = ALU_SRA; dec.is_shift = 1'b1; end
                FN_SLLV: begin dec.op = ALU_SLL; dec.is_shift = 1'b1; dec.var_amt = 1'b1; end
                FN_SRLV: begin dec.op = ALU_SRL; dec.is_shift = 1'b1; dec.var_amt = 1'b1; end
                FN_SRAV: begin dec.op = ALU_SRA; dec.is_shift = 1'b1; dec.var_amt = 1'b1; end
                default: dec.legal = 1'b0;
            endcase
        end else begin
            dec.dest    = instr[20:16];
            dec.use_imm = 1'b1;
            case (opc)
                OPC_ADDI, OPC_ADDIU: dec.op = ALU_ADD;
                OPC_ANDI:            dec.op = ALU_AND;
                OPC_ORI:             dec.op = ALU_OR;
                OPC_XORI:            dec.op = ALU_XOR;
                OPC_LUI: begin
                    dec.op    = ALU_LUI;
                    dec.legal = (instr[25:21] == 5'd0);
                end
                default:             dec.legal = 1'b0;
            endcase
        end
        if (!dec.legal) begin
            dec.dest = '0;
        end
    end

endmodule

// File: rtl/exu_shifter.sv
module exu_shifter
    import exu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] val,
    input  logic [SH_W-1:0]   amt,
    input  alu_op_e           op,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        case (op)
            ALU_SLL: res = val << amt;
            ALU_SRL: res = val >> amt;
            ALU_SRA: res = DATA_W'($signed(val) >>> amt);
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/exu_arith.sv
module exu_arith
    import exu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_op_e           op,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        case (op)
            ALU_ADD: res = a + b;
            ALU_SUB: res = a - b;
            ALU_AND: res = a & b;
            ALU_OR:  res = a | b;
            ALU_XOR: res = a ^ b;
            ALU_NOR: res = ~(a | b);
            ALU_LUI: res = b << IMM_W;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import exu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [4:0]        dest_idx,
    output logic              wr_en,
    output logic              illegal
);
    localparam int SH_W = $clog2(DATA_W);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] res;
        logic [4:0]        dest;
        logic              we;
        logic              ill;
    } out_s;

    out_s out_d, out_q;
    dec_s dec;

    logic [DATA_W-1:0] op_a, op_b, imm_ext, alu_b;
    logic [DATA_W-1:0] ar_res, sh_res;
    logic [SH_W-1:0]   sh_amt;

    exu_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    // Register 0 reads as zero regardless of the operand bus
    assign op_a    = (instr[25:21] == 5'd0) ? '0 : rs_val;
    assign op_b    = (instr[20:16] == 5'd0) ? '0 : rt_val;
    assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, instr[IMM_W-1:0]};
    assign alu_b   = dec.use_imm ? imm_ext : op_b;
    assign sh_amt  = dec.var_amt ? op_a[SH_W-1:0] : SH_W'(instr[10:6]);

    exu_arith #(.DATA_W(DATA_W)) u_arith (
        .a   (op_a),
        .b   (alu_b),
        .op  (dec.op),
        .res (ar_res)
    );

    exu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
        .val (op_b),
        .amt (sh_amt),
        .op  (dec.op),
        .res (sh_res)
    );

    always_comb begin
        out_d = '0;
        if (in_valid) begin
            out_d.valid = 1'b1;
            if (dec.legal) begin
                out_d.res  = dec.is_shift ? sh_res : ar_res;
                out_d.dest = dec.dest;
                out_d.we   = (dec.dest != 5'd0);
            end else begin
                out_d.ill  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign result    = out_q.res;
    assign dest_idx  = out_q.dest;
    assign wr_en     = out_q.we;
    assign illegal   = out_q.ill;

endmodule

// File: rtl/exu_checker.sv
module exu_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [5:0]        in_opc,
    input logic [4:0]        in_rd,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic [4:0]        dest_idx,
    input logic              wr_en,
    input logic              illegal
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!wr_en && !illegal && dest_idx == 5'd0)); // R2

    AST_REG_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(in_opc) == 6'h00) |-> dest_idx == $past(in_rd)); // R3

    AST_LUI_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(in_opc) == 6'h0F) |-> result[15:0] == 16'h0000); // R8

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_en && result == '0 && dest_idx == 5'd0 && out_valid)); // R10

    AST_NO_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> dest_idx != 5'd0); // R11

endmodule

bind int_exec_unit exu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_opc    (instr[31:26]),
    .in_rd     (instr[15:11]),
    .out_valid (out_valid),
    .result    (result),
    .dest_idx  (dest_idx),
    .wr_en     (wr_en),
    .illegal   (illegal)
);

// File: tb/int_exec_unit_tb.sv
`timescale 1ns/1ps
module int_exec_unit_tb;

    typedef struct packed {
        logic        valid;
        logic [31:0] res;
        logic [4:0]  dest;
        logic        we;
        logic        ill;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic        out_valid;
    logic [31:0] result;
    logic [4:0]  dest_idx;
    logic        wr_en;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    int_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .out_valid(out_valid),
        .result(result), .dest_idx(dest_idx), .wr_en(wr_en), .illegal(illegal)
    );

    function automatic void model(input logic v, input logic [31:0] ins,
                                  input logic [31:0] a, input logic [31:0] b,
                                  output exp_t e, output string tag);
        logic [5:0]  opc = ins[31:26];
        logic [5:0]  fn  = ins[5:0];
        logic [4:0]  rsi = ins[25:21];
        logic [4:0]  rti = ins[20:16];
        logic [31:0] av  = (rsi == 0) ? 32'd0 : a;
        logic [31:0] bv  = (rti == 0) ? 32'd0 : b;
        logic [31:0] imm = {16'd0, ins[15:0]};
        int          sh  = int'(ins[10:6]);
        int          vs  = int'(av[4:0]);
        logic        ok  = 1'b1;
        logic        uses_rs = 1'b1;
        e = '0;
        tag = "R2";
        if (!v) return;
        e.valid = 1'b1;
        if (opc == 6'h00) begin
            e.dest = ins[15:11];
            case (fn)
                6'h20, 6'h21: begin e.res = av + bv; tag = "R3"; end
                6'h22, 6'h23: begin e.res = av - bv; tag = "R3"; end
                6'h24: begin e.res = av & bv; tag = "R4"; end
                6'h25: begin e.res = av | bv; tag = "R4"; end
                6'h26: begin e.res = av ^ bv; tag = "R4"; end
                6'h27: begin e.res = ~(av | bv); tag = "R4"; end
                6'h00: begin e.res = bv << sh; tag = "R5"; uses_rs = 0; end
                6'h02: begin e.res = bv >> sh; tag = "R5"; uses_rs = 0; end
                6'h03: begin e.res = 32'($signed(bv) >>> sh); tag = "R5"; uses_rs = 0; end
                6'h04: begin e.res = bv << vs; tag = "R6"; end
                6'h06: begin e.res = bv >> vs; tag = "R6"; end
                6'h07: begin e.res = 32'($signed(bv) >>> vs); tag = "R6"; end
                default: ok = 1'b0;
            endcase
            if (ok && (rsi == 0 && a != 0 && uses_rs || rti == 0 && b != 0)) tag = "R9";
        end else begin
            e.dest = rti;
            case (opc)
                6'h08, 6'h09: begin e.res = av + imm; tag = "R7"; end
                6'h0C: begin e.res = av & imm; tag = "R7"; end
                6'h0D: begin e.res = av | imm; tag = "R7"; end
                6'h0E: begin e.res = av ^ imm; tag = "R7"; end
                6'h0F: begin
                    if (rsi == 0) begin e.res = {ins[15:0], 16'h0000}; tag = "R8"; end
                    else ok = 1'b0;
                end
                default: ok = 1'b0;
            endcase
            if (ok && opc != 6'h0F && rsi == 0 && a != 0) tag = "R9";
        end
        if (!ok) begin
            e.res = '0; e.dest = '0; e.ill = 1'b1; tag = "R10";
        end else begin
            e.we = (e.dest != 0);
            if (e.dest == 0) tag = "R11";
        end
    endfunction

    task automatic compare(input exp_t e, input string tag);
        checks++;
        if (out_valid !== e.valid || result !== e.res || dest_idx !== e.dest ||
            wr_en !== e.we || illegal !== e.ill) begin
            errors++;
            $display("FAIL %s: got v=%0b res=%h dst=%0d we=%0b ill=%0b, expected v=%0b res=%h dst=%0d we=%0b ill=%0b",
                     tag, out_valid, result, dest_idx, wr_en, illegal,
                     e.valid, e.res, e.dest, e.we, e.ill);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b);
        exp_t  e;
        string t;
        @(negedge clk);
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        in_valid = v; instr = ins; rs_val = a; rt_val = b;
        model(v, ins, a, b, e, t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    function automatic logic [31:0] rtype(input int rs, input int rt, input int rd,
                                          input int sh, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
    endfunction

    function automatic logic [31:0] itype(input logic [5:0] opc, input int rs,
                                          input int rt, input logic [15:0] imm);
        return {opc, 5'(rs), 5'(rt), imm};
    endfunction

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] opcs [0:9];
        logic [5:0] fns  [0:15];
        opcs = '{6'h00, 6'h00, 6'h00, 6'h08, 6'h09, 6'h0C, 6'h0D, 6'h0E, 6'h0F, 6'h00};
        fns  = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27,
                 6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07, 6'h01, 6'h18};

        // R1: outputs cleared during reset, even with an instruction presented
        in_valid = 1'b1;
        instr = rtype(1, 2, 3, 0, 6'h20);
        rs_val = 32'h1; rt_val = 32'h2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 0 || result !== 0 || dest_idx !== 0 || wr_en !== 0 || illegal !== 0) begin
            errors++;
            $display("FAIL R1: got v=%0b res=%h dst=%0d we=%0b ill=%0b, expected all zero",
                     out_valid, result, dest_idx, wr_en, illegal);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R3 add/sub with wrap-around
        step(1, rtype(1, 2, 3, 0, 6'h20), 32'hFFFF_FFFF, 32'h2);
        step(1, rtype(4, 5, 6, 0, 6'h23), 32'h0, 32'h1);
        // R4 logic ops
        step(1, rtype(7, 8, 9, 0, 6'h27), 32'hF0F0_0000, 32'h0000_0F0F);
        step(1, rtype(7, 8, 9, 0, 6'h26), 32'hAAAA_5555, 32'hFFFF_0000);
        // R5 fixed shifts; rs field nonzero must not matter
        step(1, rtype(9, 2, 10, 4, 6'h03), 32'h7, 32'h8000_0010);
        step(1, rtype(0, 2, 10, 31, 6'h02), 32'h0, 32'h8000_0000);
        // R6 variable shifts, amount from low 5 bits of rs
        step(1, rtype(3, 2, 11, 0, 6'h07), 32'hFFFF_FFE4, 32'h8000_0000);
        step(1, rtype(3, 2, 11, 0, 6'h04), 32'h21, 32'h1);
        // R7 immediates zero-extended, including addi
        step(1, itype(6'h08, 1, 12, 16'hFFFF), 32'h1, 32'h0);
        step(1, itype(6'h0D, 1, 12, 16'h8000), 32'h1, 32'h0);
        // R8 load upper
        step(1, itype(6'h0F, 0, 13, 16'hBEEF), 32'h0, 32'h1234_5678);
        // R9 register 0 reads zero
        step(1, rtype(0, 0, 14, 0, 6'h25), 32'hDEAD_BEEF, 32'h1234_5678);
        // R10 illegal codes
        step(1, rtype(1, 2, 3, 0, 6'h18), 32'h5, 32'h6);
        step(1, itype(6'h23, 1, 2, 16'h0004), 32'h5, 32'h6);
        step(1, itype(6'h0F, 3, 13, 16'h0001), 32'h5, 32'h6);
        // R11 destination zero
        step(1, rtype(1, 2, 0, 0, 6'h21), 32'h5, 32'h6);
        // R2 idle gap clears the outputs
        step(0, rtype(1, 2, 3, 0, 6'h20), 32'h5, 32'h6);
        step(0, 32'h0, 32'h0, 32'h0);

        for (int i = 0; i < 3000; i++) begin
            logic [5:0]  o = opcs[$urandom_range(0, 9)];
            logic [31:0] ins;
            if ($urandom_range(0, 9) == 0) o = 6'($urandom());
            if (o == 6'h00)
                ins = {6'h00, 5'($urandom_range(0, 3) == 0 ? 0 : $urandom()),
                       5'($urandom_range(0, 3) == 0 ? 0 : $urandom()),
                       5'($urandom()), 5'($urandom()), fns[$urandom_range(0, 15)]};
            else
                ins = {o, 5'($urandom_range(0, 3) == 0 ? 0 : $urandom()),
                       5'($urandom()), 16'($urandom())};
            step($urandom_range(0, 7) != 0, ins, $urandom(), $urandom());
        end
        step(0, 32'h0, 32'h0, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule